// File: doc/BRIEF.md
# Video control signal glitch filter

This block cleans up the three slow video control lines (data enable, horizontal sync and vertical sync) in the pixel clock domain before they reach the display timing logic. Each line goes through its own channel. A channel commits a new output level only when that change fits a rate budget counted over a sliding window of 130 pixel clocks. When filtering is switched on, the data enable and horizontal sync channels also require a new level to hold for a minimum number of clocks. A noise spike on a control line therefore never reaches the display, while genuine timing edges pass with a fixed latency.

A two-bit mode input selects the behaviour. The two normal modes differ only in the minimum-width check. The two legacy modes bypass the conditioning and register each line once. The control lines carry no back-pressure: they are plain level signals sampled on every clock, so there is no valid/ready handshake. The mode input is a static configuration pin and is expected to change only rarely.

Top module: `vidctl_deglitch`

## Requirements
- R1: While rst_n is low all three outputs are 0, and every channel's transition history is cleared, so the first transition after reset is never held back by the window.
- R2: In the normal modes (00 and 01), de_out and hs_out each change at most twice in any 130 consecutive clocks: for three successive output changes at edges t1 < t2 < t3, t3 - t1 >= 130.
- R3: In mode 01 a new data enable or horizontal sync level is committed only after the input has been sampled at that level on 3 consecutive edges; a shorter pulse is dropped and the output keeps its previous level.
- R4: In the normal modes, two successive vs_out changes lie at least 130 clocks apart. Vertical sync never gets the minimum-width check, in either normal mode.
- R5: In mode 00 data enable and horizontal sync get no width check: a pulse of 1 or 2 clocks passes unchanged in length whenever the window budget allows it.
- R6: In the normal modes an input level sampled at edge k reaches the output at edge k+3, unless R2, R3 or R4 hold it back.
- R7: In modes 10 and 11 each output equals its input as sampled at the previous clock edge, with no window or width rule, and the window history stays empty.
- R8: A transition held back by the window is deferred, not lost. If the input still differs from the output, the output takes the new level at the first edge the window allows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 normal without width check, 01 normal with width check, 10/11 legacy pass-through |
| de_in | input | 1 | Raw data enable |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| de_out | output | 1 | Conditioned data enable |
| hs_out | output | 1 | Conditioned horizontal sync |
| vs_out | output | 1 | Conditioned vertical sync |

## Verification
Some properties are checked on every clock once the mode has been steady for a few cycles. Each channel's output changes respect the window budget, which is tracked from the output pins alone. A committed level equals the input from four samples back. With the width check on, that level has held for three samples. In legacy mode each output is the previous input. Other behaviours need a full scenario to show, and only the bench's scenarios can exercise them. These are that a blocked edge is delayed and not lost, that a dropped glitch leaves no trace on a later pulse, that the outputs are low in reset, and that every mode gives the exact edge timing under dense and sparse toggle patterns. The bench checks this timing against an independent behavioural model of the rules.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;
  typedef enum logic [1:0] {
    MODE_NORM_RAW  = 2'b00,
    MODE_NORM_FILT = 2'b01,
    MODE_LEGACY_A  = 2'b10,
    MODE_LEGACY_B  = 2'b11
  } ctl_mode_e;

  localparam int NUM_CTL = 3;
endpackage

// File: rtl/ctl_age_window.sv
// Tracks the age of the last BUDGET committed transitions of one channel
// and reports when another transition fits inside the sliding window.
module ctl_age_window #(
  parameter int WINDOW = 130,
  parameter int BUDGET = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic commit,
  output logic open
);
  localparam int AW = $clog2(WINDOW + 1);
  localparam logic [AW-1:0] FULL = AW'(WINDOW);

  logic [AW-1:0] age_q [BUDGET];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return (a >= FULL) ? FULL : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUDGET; i++) age_q[i] <= FULL;
    end else if (clear) begin
      for (int i = 0; i < BUDGET; i++) age_q[i] <= FULL;
    end else if (commit) begin
      age_q[0] <= AW'(1);
      for (int i = 1; i < BUDGET; i++) age_q[i] <= bump(age_q[i-1]);
    end else begin
      for (int i = 0; i < BUDGET; i++) age_q[i] <= bump(age_q[i]);
    end
  end

  // Oldest remembered transition has left the window.
  assign open = (age_q[BUDGET-1] >= FULL);
endmodule

// File: rtl/ctl_rate_gate.sv
// One control line: sample pipeline, optional minimum-width check,
// window budget gate and output register.
module ctl_rate_gate #(
  parameter int WINDOW  = 130,
  parameter int BUDGET  = 2,
  parameter int PIPE    = 3,
  parameter bit MINW_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic legacy,
  input  logic filt_en,
  input  logic din,
  output logic dout
);
  localparam int AW = $clog2(WINDOW + 1);
  localparam logic [AW-1:0] FULL = AW'(WINDOW);

  logic [PIPE-1:0] dq;
  logic            stable, use_min, prop, open, commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dq <= '0;
    else        dq <= {dq[PIPE-2:0], din};
  end

  assign stable = (&dq) | (~|dq);

  generate
    if (MINW_EN) begin : g_minw
      assign use_min = filt_en;
    end else begin : g_nominw
      assign use_min = 1'b0;
    end
  endgenerate

  assign prop   = (use_min && !stable) ? dout : dq[PIPE-1];
  assign commit = !legacy && (prop != dout) && open;

  ctl_age_window #(.WINDOW(WINDOW), .BUDGET(BUDGET)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (legacy),
    .commit (commit),
    .open   (open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout <= 1'b0;
    else if (legacy) dout <= din;
    else if (commit) dout <= prop;
  end

  // ---------------- assertions ----------------
  logic [2:0]    steady_q;
  logic [1:0]    cfg_q;
  logic          dout_q;
  logic [AW-1:0] chk_age [BUDGET];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steady_q <= '0;
      cfg_q    <= '0;
      dout_q   <= 1'b0;
    end else begin
      cfg_q    <= {legacy, use_min};
      dout_q   <= dout;
      if (cfg_q != {legacy, use_min}) steady_q <= '0;
      else if (steady_q != 3'd7)      steady_q <= steady_q + 3'd1;
    end
  end

  // Output-side transition ages, independent of the gate's own history.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || legacy) begin
      for (int i = 0; i < BUDGET; i++) chk_age[i] <= FULL;
    end else if (dout != dout_q) begin
      chk_age[0] <= AW'(1);
      for (int i = 1; i < BUDGET; i++)
        chk_age[i] <= (chk_age[i-1] >= FULL) ? FULL : chk_age[i-1] + 1'b1;
    end else begin
      for (int i = 0; i < BUDGET; i++)
        chk_age[i] <= (chk_age[i] >= FULL) ? FULL : chk_age[i] + 1'b1;
    end
  end

  // R2 for DE/HS, R4 for VS: budget over the sliding window.
  assert_window_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy && steady_q >= 3'd2 && dout != dout_q) |-> chk_age[BUDGET-1] >= FULL);

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy && steady_q >= 3'd6 && dout != $past(dout)) |-> dout == $past(din, 4));

  assert_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy && use_min && steady_q >= 3'd6 && dout != $past(dout)) |->
      (dout == $past(din, 2) && dout == $past(din, 3) && dout == $past(din, 4)));

  assert_legacy_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy && steady_q >= 3'd2) |=> dout == $past(din));
endmodule

// File: rtl/vidctl_deglitch.sv
module vidctl_deglitch #(
  parameter int WINDOW      = 130,
  parameter int FAST_BUDGET = 2,
  parameter int SLOW_BUDGET = 1,
  parameter int MIN_WIDTH   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       de_in,
  input  logic       hs_in,
  input  logic       vs_in,
  output logic       de_out,
  output logic       hs_out,
  output logic       vs_out
);
  import vidctl_pkg::*;

  logic                legacy, filt_en;
  logic [NUM_CTL-1:0]  raw, flt;

  assign legacy  = mode[1];
  assign filt_en = (ctl_mode_e'(mode) == MODE_NORM_FILT);
  assign raw     = {vs_in, hs_in, de_in};

  // Index 0: DE, 1: HS, 2: VS (slow line, single-transition budget).
  generate
    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ch
      localparam int  BUD = (g == NUM_CTL - 1) ? SLOW_BUDGET : FAST_BUDGET;
      localparam bit  MW  = (g == NUM_CTL - 1) ? 1'b0 : 1'b1;
      ctl_rate_gate #(
        .WINDOW (WINDOW),
        .BUDGET (BUD),
        .PIPE   (MIN_WIDTH),
        .MINW_EN(MW)
      ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .legacy (legacy),
        .filt_en(filt_en),
        .din    (raw[g]),
        .dout   (flt[g])
      );
    end
  endgenerate

  assign de_out = flt[0];
  assign hs_out = flt[1];
  assign vs_out = flt[2];
endmodule

// File: tb/tb_vidctl_deglitch.sv
`timescale 1ns/1ps
module tb_vidctl_deglitch;
  localparam int W = 130;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
  logic       de_out, hs_out, vs_out;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  vidctl_deglitch dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
    .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out)
  );

  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; de_in = 0; hs_in = 0; vs_in = 0; mode = m;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  // ---------------- behavioural model ----------------
  bit  model_on = 1'b0;
  int  cyc = 0;
  bit  h [3][3];
  bit  mout [3];
  int  tc [3][2];

  always @(posedge clk) begin
    logic [2:0] inv;
    inv = {vs_in, hs_in, de_in};
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        mout[c] = 0; tc[c][0] = -100000; tc[c][1] = -100000;
        for (int j = 0; j < 3; j++) h[c][j] = 0;
      end
    end else begin
      for (int c = 0; c < 3; c++) begin
        int  bud;
        bit  filt, prop, stab, nout;
        bud  = (c == 2) ? 1 : 2;
        filt = (mode == 2'b01) && (c < 2);
        nout = mout[c];
        if (mode[1]) begin
          nout = inv[c];
          tc[c][0] = -100000; tc[c][1] = -100000;
        end else begin
          stab = (h[c][0] == h[c][1]) && (h[c][1] == h[c][2]);
          prop = (filt && !stab) ? mout[c] : h[c][2];
          if (prop != mout[c] && (cyc - tc[c][bud-1]) >= W) begin
            nout = prop;
            tc[c][1] = tc[c][0];
            tc[c][0] = cyc;
          end
        end
        h[c][2] = h[c][1]; h[c][1] = h[c][0]; h[c][0] = inv[c];
        mout[c] = nout;
      end
    end
    cyc++;
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      string tag;
      tag = mode[1] ? "R7" : (mode == 2'b01 ? "R3" : "R5");
      chk(tag, "sweep de", de_out, mout[0]);
      chk(tag, "sweep hs", hs_out, mout[1]);
      chk(mode[1] ? "R7" : "R4", "sweep vs", vs_out, mout[2]);
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 10);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [15:0] lf;
    int ths [3];
    ths[0] = 1; ths[1] = 3; ths[2] = 9;
    @(negedge clk);

    // R1: outputs low in reset and just after.
    rst_n = 1'b0; de_in = 1; hs_in = 1; vs_in = 1; mode = 2'b10;
    step();
    chk("R1", "de in reset", de_out, 1'b0);
    chk("R1", "hs in reset", hs_out, 1'b0);
    chk("R1", "vs in reset", vs_out, 1'b0);

    // R5 / R6: mode 00, 2-clock DE pulse passes with 3-clock latency.
    do_reset(2'b00);
    for (int n = 1; n <= 8; n++) begin
      de_in = (n <= 2);
      step();
      if (n == 3) chk("R6", "de latency before", de_out, 1'b0);
      if (n == 4) chk("R5", "short pulse rise", de_out, 1'b1);
      if (n == 5) chk("R5", "short pulse held", de_out, 1'b1);
      if (n == 6) chk("R5", "short pulse fall", de_out, 1'b0);
    end

    // R3: mode 01, 2-clock pulse dropped, 3-clock pulse passes.
    do_reset(2'b01);
    for (int n = 1; n <= 10; n++) begin
      de_in = (n <= 2);
      step();
      chk("R3", "glitch dropped", de_out, 1'b0);
    end
    for (int n = 1; n <= 8; n++) begin
      hs_in = (n <= 3);
      step();
      if (n == 3) chk("R3", "hs before commit", hs_out, 1'b0);
      if (n == 4) chk("R3", "3-clock pulse rise", hs_out, 1'b1);
      if (n == 6) chk("R3", "3-clock pulse held", hs_out, 1'b1);
      if (n == 7) chk("R3", "3-clock pulse fall", hs_out, 1'b0);
    end

    // R2 / R8: third HS edge waits for the window, then commits.
    do_reset(2'b00);
    for (int n = 1; n <= 140; n++) begin
      hs_in = (n <= 5) || (n > 10);
      step();
      if (n == 4)   chk("R2", "first edge", hs_out, 1'b1);
      if (n == 9)   chk("R2", "second edge", hs_out, 1'b0);
      if (n == 20)  chk("R2", "third edge blocked", hs_out, 1'b0);
      if (n == 133) chk("R8", "still blocked", hs_out, 1'b0);
      if (n == 134) chk("R8", "deferred edge", hs_out, 1'b1);
    end

    // R4: VS second edge needs 130 clocks, no width check on VS.
    do_reset(2'b01);
    for (int n = 1; n <= 140; n++) begin
      vs_in = (n == 1) ? 1'b1 : (n <= 10);
      step();
      if (n == 4)   chk("R4", "vs rise", vs_out, 1'b1);
      if (n == 133) chk("R4", "vs fall blocked", vs_out, 1'b1);
      if (n == 134) chk("R4", "vs fall allowed", vs_out, 1'b0);
    end

    // R7: legacy modes pass a 1-clock pulse registered once.
    do_reset(2'b10);
    for (int n = 1; n <= 3; n++) begin
      de_in = (n == 1);
      step();
      if (n == 1) chk("R7", "legacy de pulse", de_out, 1'b1);
      if (n == 2) chk("R7", "legacy de clear", de_out, 1'b0);
    end
    mode = 2'b11;
    for (int n = 1; n <= 3; n++) begin
      vs_in = (n == 1);
      step();
      if (n == 1) chk("R7", "legacy vs pulse", vs_out, 1'b1);
      if (n == 2) chk("R7", "legacy vs clear", vs_out, 1'b0);
    end

    // Sweep: every mode under three toggle densities against the model.
    do_reset(2'b00);
    model_on = 1'b1;
    lf = 16'hACE1;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int p = 0; p < 3; p++) begin
        for (int k = 0; k < 1500; k++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          if (int'(lf[3:0]) < ths[p])  de_in = ~de_in;
          if (int'(lf[7:4]) < ths[p])  hs_in = ~hs_in;
          if (int'(lf[11:8]) < ths[p]) vs_in = ~vs_in;
          step();
        end
      end
    end
    model_on = 1'b0;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule